// File: doc/BRIEF.md
# 513-bit Transcoded Word Unpacker with Early First-Byte Decode

This block rebuilds eight 66-bit line-code blocks from one 513-bit transcoded word. The word arrives 64 bits per clock over eight beats. The opening beat is marked by a start-of-word strobe and carries the one-bit header. It also carries a 64-bit field that holds one first-byte slot for each of the eight original blocks. The seven beats after it carry the 56 remaining payload bytes. Those bytes sit at fixed positions and are written straight into their home blocks with no selection logic.

Every routing decision for the first bytes is taken while the opening beat is on the bus. This covers which blocks are control blocks, which slot feeds which block, and whether the word is malformed. Only byte-wide multiplexers are involved, and the result is held in a register until the payload has arrived. The eight rebuilt blocks then appear together with a one-cycle valid and an error flag.

With the header clear, all eight blocks are data blocks. With the header set, a chain of control descriptors fills the leading slots. Each descriptor names a block index and a 4-bit type code, and the code is expanded back into the full 8-bit block type.

Top module: `tcw_unpack`

## Requirements
- R1: A word is eight beats on `in_data`.
  - Beat 0 has `in_sow` high and carries `in_hdr`, plus the first-byte field, with slot s at bits [8s+7:8s].
  - Beats 1 to 7 carry payload bytes 0 to 55. Payload byte j is on beat 1+j/8, lane j%8, and lane l is bits [8l+7:8l]. Byte j becomes byte 1+(j%7) of block j/7, where byte 0 is the first byte.
  - Block b appears on `out_blocks[66b+65:66b]`. Its 2-bit sync field is at [1:0] and its byte m is at [8m+9:8m+2].
- R2: With `in_hdr` = 0, every block has sync 2'b01 and first byte equal to slot b, and `out_err` stays 0, whatever the slot contents look like.
- R3: With `in_hdr` = 1, each slot from slot 0 upward is a descriptor, and the chain stops after the first slot whose continue bit is 0.
  - A descriptor has the block index in bits [7:5], the continue bit in bit 4 and the type code in bits [3:0].
  - The named block gets sync 2'b10 and an expanded type byte. Codes 0 to 14 expand to 1E, 2D, 33, 66, 55, 78, 4B, 87, 99, AA, B4, CC, D2, E1 and FF (hex), in that order.
- R4: The slots after the descriptor chain go, in slot order, to the blocks not named by any descriptor, taken in ascending block index. Each such block gets sync 2'b01.
- R5: `out_err` is 1 when two descriptors in the chain name the same block index.
- R6: `out_err` is 1 when a descriptor in the chain carries type code 15.
- R7: `out_err` is 1 when all eight slots have the continue bit set.
- R8: `out_valid` is high for exactly one cycle. That cycle follows the clock edge that samples payload beat 7, and `out_valid` is never high earlier. `out_err` is high only together with `out_valid`.
- R9: A start-of-word beat that arrives inside an unfinished word discards that word and starts a new one. The discarded word produces no output.
- R10: Cycles with `in_valid` low stall a word without disturbing it. Beats that have `in_valid` high and `in_sow` low outside a word are ignored.
- R11: While reset is low, `out_valid` and `out_err` are 0. A word cut off by reset produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Beat on `in_data` is present |
| in_sow | input | 1 | Marks the opening beat of a word |
| in_hdr | input | 1 | Header bit, sampled with the opening beat |
| in_data | input | 64 | Beat data: first-byte field, then payload |
| out_valid | output | 1 | One-cycle strobe, rebuilt blocks are present |
| out_err | output | 1 | Malformed descriptor chain, qualified by `out_valid` |
| out_blocks | output | 528 | Eight rebuilt 66-bit blocks, block b at [66b+65:66b] |

## Verification
The first-byte decode is registered on the edge that samples the opening beat, and payload beats are registered on their own edges. `out_valid`, `out_err` and `out_blocks` all change on the edge that samples payload beat 7, so they are due one cycle after that beat is driven. Inputs are driven and outputs sampled on falling edges. The bench therefore reads the results at the first falling edge after the last beat, and confirms at the following falling edge that the strobe has dropped. At every falling edge before the last beat, `out_valid` is expected low; this holds equally with stall cycles, discarded words and stray beats.

// File: rtl/tcw_pkg.sv
`timescale 1ns/1ps
package tcw_pkg;
  localparam int NBLK       = 8;
  localparam int BYTE_W     = 8;
  localparam int SYNC_W     = 2;
  localparam int BLK_BYTES  = 8;
  localparam int BLK_W      = SYNC_W + BLK_BYTES * BYTE_W;
  localparam int BEAT_W     = 64;
  localparam int FB_W       = NBLK * BYTE_W;
  localparam int TAIL_W     = (BLK_BYTES - 1) * BYTE_W;
  localparam int PAY_W      = NBLK * TAIL_W;
  localparam int PAY_BEATS  = PAY_W / BEAT_W;
  localparam int OUT_W      = NBLK * BLK_W;
  localparam int IDX_W      = $clog2(NBLK);
  localparam int IDX_LSB    = 5;
  localparam int CONT_BIT   = 4;
  localparam int CODE_W     = 4;
  localparam int CNT_W      = $clog2(NBLK + 1);
  localparam int RANK_W     = CNT_W + 1;
  localparam int BEAT_CNT_W = $clog2(PAY_BEATS + 1);

  localparam logic [CODE_W-1:0] CODE_BAD  = 4'hF;
  localparam logic [SYNC_W-1:0] SYNC_CTRL = 2'b10;
  localparam logic [SYNC_W-1:0] SYNC_DATA = 2'b01;

  // 4-bit compressed code back to the full block type byte
  function automatic logic [BYTE_W-1:0] expand_type(input logic [CODE_W-1:0] code);
    logic [BYTE_W-1:0] t;
    case (code)
      4'h0: t = 8'h1E;
      4'h1: t = 8'h2D;
      4'h2: t = 8'h33;
      4'h3: t = 8'h66;
      4'h4: t = 8'h55;
      4'h5: t = 8'h78;
      4'h6: t = 8'h4B;
      4'h7: t = 8'h87;
      4'h8: t = 8'h99;
      4'h9: t = 8'hAA;
      4'hA: t = 8'hB4;
      4'hB: t = 8'hCC;
      4'hC: t = 8'hD2;
      4'hD: t = 8'hE1;
      4'hE: t = 8'hFF;
      default: t = 8'h00;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/tcw_fb_resolve.sv
`timescale 1ns/1ps
module tcw_fb_resolve
  import tcw_pkg::*;
(
  input  logic                        hdr_i,
  input  logic [FB_W-1:0]             slots_i,
  output logic [NBLK-1:0][BYTE_W-1:0] fb_o,
  output logic [NBLK-1:0]             ctrl_o,
  output logic [CNT_W-1:0]            ndesc_o,
  output logic                        err_o
);
  logic [NBLK-1:0][BYTE_W-1:0] slot;
  logic [NBLK-1:0][BYTE_W-1:0] ctype;
  logic [NBLK-1:0]             stop;
  logic [NBLK-1:0]             ctrl;
  logic [CNT_W-1:0]            ndesc;
  logic [RANK_W-1:0]           rank;
  logic [IDX_W-1:0]            idx;
  logic                        chain_err;
  logic                        dup_err;
  logic                        code_err;

  assign slot = slots_i;

  generate
    for (genvar s = 0; s < NBLK; s++) begin : g_stop
      assign stop[s] = ~slot[s][CONT_BIT];
    end
  endgenerate

  // length of the descriptor chain: lowest slot with continue clear
  always_comb begin : chain_len
    ndesc = CNT_W'(NBLK);
    for (int s = NBLK - 1; s >= 0; s--) begin
      if (stop[s]) ndesc = CNT_W'(s + 1);
    end
    if (!hdr_i) ndesc = '0;
    chain_err = hdr_i & ~|stop;
  end

  // mark control blocks and pick up their expanded types
  always_comb begin : desc_map
    ctrl     = '0;
    ctype    = '0;
    dup_err  = 1'b0;
    code_err = 1'b0;
    idx      = '0;
    for (int s = 0; s < NBLK; s++) begin
      if (CNT_W'(s) < ndesc) begin
        idx        = slot[s][IDX_LSB +: IDX_W];
        dup_err    = dup_err | ctrl[idx];
        ctrl[idx]  = 1'b1;
        ctype[idx] = expand_type(slot[s][CODE_W-1:0]);
        code_err   = code_err | (slot[s][CODE_W-1:0] == CODE_BAD);
      end
    end
  end

  // hand leftover slots to unmarked blocks in ascending order
  always_comb begin : fill
    rank = RANK_W'(ndesc);
    fb_o = '0;
    for (int b = 0; b < NBLK; b++) begin
      if (ctrl[b]) begin
        fb_o[b] = ctype[b];
      end else begin
        if (rank < RANK_W'(NBLK)) fb_o[b] = slot[rank[IDX_W-1:0]];
        rank = rank + RANK_W'(1);
      end
    end
  end

  assign ctrl_o  = ctrl;
  assign ndesc_o = ndesc;
  assign err_o   = chain_err | dup_err | code_err;
endmodule

// File: rtl/tcw_beat_ctrl.sv
`timescale 1ns/1ps
module tcw_beat_ctrl
  import tcw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_q,
  input  logic                 in_valid,
  input  logic                 in_sow,
  output logic                 cap_o,
  output logic [PAY_BEATS-1:0] wr_o,
  output logic                 done_o
);
  logic                  active_q, active_d;
  logic [BEAT_CNT_W-1:0] cnt_q, cnt_d;
  logic                  done_d;
  logic                  pay_beat;

  assign pay_beat = in_valid & ~in_sow & active_q;
  assign cap_o    = in_valid & in_sow;

  generate
    for (genvar k = 0; k < PAY_BEATS; k++) begin : g_wr
      assign wr_o[k] = pay_beat & (cnt_q == BEAT_CNT_W'(k + 1));
    end
  endgenerate

  always_comb begin : nxt
    active_d = active_q;
    cnt_d    = cnt_q;
    done_d   = 1'b0;
    if (cap_o) begin
      active_d = 1'b1;
      cnt_d    = BEAT_CNT_W'(1);
    end else if (pay_beat) begin
      if (cnt_q == BEAT_CNT_W'(PAY_BEATS)) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + BEAT_CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin : regs
    if (!rst_q) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_o   <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      done_o   <= done_d;
    end
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |=> !done_o);

  // R8
  valid_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done_o |-> $past(in_valid && !in_sow));
endmodule

// File: rtl/tcw_unpack.sv
`timescale 1ns/1ps
module tcw_unpack
  import tcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sow,
  input  logic              in_hdr,
  input  logic [BEAT_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_err,
  output logic [OUT_W-1:0]  out_blocks
);
  logic [1:0]                  rs_q;
  logic                        rst_q;
  logic [NBLK-1:0][BYTE_W-1:0] res_fb;
  logic [NBLK-1:0]             res_ctrl;
  logic [CNT_W-1:0]            res_ndesc;
  logic                        res_err;
  logic                        cap;
  logic [PAY_BEATS-1:0]        wr;
  logic                        done;

  logic [NBLK-1:0][BYTE_W-1:0] fb_q, fb_d;
  logic [NBLK-1:0]             ctrl_q, ctrl_d;
  logic                        err_q, err_d;
  logic [PAY_W-1:0]            pay_q, pay_d;
  logic                        oerr_q, oerr_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin : rst_sync
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  tcw_fb_resolve u_res (
    .hdr_i   (in_hdr),
    .slots_i (in_data),
    .fb_o    (res_fb),
    .ctrl_o  (res_ctrl),
    .ndesc_o (res_ndesc),
    .err_o   (res_err)
  );

  tcw_beat_ctrl u_ctl (
    .clk      (clk),
    .rst_q    (rst_q),
    .in_valid (in_valid),
    .in_sow   (in_sow),
    .cap_o    (cap),
    .wr_o     (wr),
    .done_o   (done)
  );

  always_comb begin : nxt
    fb_d   = cap ? res_fb   : fb_q;
    ctrl_d = cap ? res_ctrl : ctrl_q;
    err_d  = cap ? res_err  : err_q;
    pay_d  = pay_q;
    for (int k = 0; k < PAY_BEATS; k++) begin
      if (wr[k]) pay_d[k*BEAT_W +: BEAT_W] = in_data;
    end
    oerr_d = (wr[PAY_BEATS-1]) ? err_q : 1'b0;
  end

  // datapath registers, enable-only
  always_ff @(posedge clk) begin : dp_regs
    fb_q   <= fb_d;
    ctrl_q <= ctrl_d;
    err_q  <= err_d;
    pay_q  <= pay_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin : flag_regs
    if (!rst_q) oerr_q <= 1'b0;
    else        oerr_q <= oerr_d;
  end

  generate
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
      assign out_blocks[b*BLK_W +: SYNC_W]          = ctrl_q[b] ? SYNC_CTRL : SYNC_DATA;
      assign out_blocks[b*BLK_W + SYNC_W +: BYTE_W] = fb_q[b];
      assign out_blocks[b*BLK_W + SYNC_W + BYTE_W +: TAIL_W] = pay_q[b*TAIL_W +: TAIL_W];
    end
  endgenerate

  assign out_valid = done;
  assign out_err   = oerr_q;

  // R2
  hdr0_clean_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_sow && !in_hdr) |=> (ctrl_q == '0 && !err_q));

  // R3
  ctrl_count_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && in_sow && in_hdr && !res_err) |-> ($countones(res_ctrl) == int'(res_ndesc)));

  // R8
  err_qualified_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_err |-> out_valid);
endmodule

// File: tb/sim_tcw_unpack.sv
`timescale 1ns/1ps
module sim_tcw_unpack;
  localparam int NB = 8;
  localparam int OW = 528;
  localparam int PW = 448;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_sow = 1'b0;
  logic          in_hdr = 1'b0;
  logic [63:0]   in_data = '0;
  logic          out_valid;
  logic          out_err;
  logic [OW-1:0] out_blocks;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tcw_unpack u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sow     (in_sow),
    .in_hdr     (in_hdr),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_blocks (out_blocks)
  );

  localparam logic [7:0] TYPES [15] = '{8'h1E, 8'h2D, 8'h33, 8'h66, 8'h55, 8'h78, 8'h4B,
                                        8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};

  // {header, first-byte field, expected error}
  localparam logic [65:0] VEC [8] = '{
    {1'b0, 64'h8877665544332211, 1'b0},
    {1'b1, 64'h1716151413121160, 1'b0},
    {1'b1, 64'hA7A6A5A4A3A20EF4, 1'b0},
    {1'b1, 64'hE7D6B59473523110, 1'b0},
    {1'b1, 64'h0000000000004251, 1'b1},
    {1'b1, 64'h000000000000002F, 1'b1},
    {1'b1, 64'hF1D1B19171513111, 1'b1},
    {1'b0, 64'hFFFFFFFFFFFFFFFF, 1'b0}
  };
  string vtag [8] = '{"R2 all data", "R3 R4 one control", "R3 R4 two controls",
                      "R3 all control", "R5 repeated index", "R6 unused code",
                      "R7 chain overflow", "R2 descriptor-like slots"};

  task automatic chk(input bit ok, input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [PW-1:0] mk_pay(input int v);
    logic [PW-1:0] p;
    for (int j = 0; j < 56; j++) p[8*j +: 8] = 8'(j * 7 + v * 29 + 3);
    return p;
  endfunction

  function automatic logic [OW-1:0] model(input logic h, input logic [63:0] f, input logic [PW-1:0] p);
    logic [OW-1:0] r;
    bit            isc [NB];
    logic [7:0]    first [NB];
    int            n, nxt, id;
    bit            more;
    for (int b = 0; b < NB; b++) begin isc[b] = 0; first[b] = '0; end
    n = 0;
    more = h;
    while (more && n < NB) begin
      id = int'(f[8*n+5 +: 3]);
      isc[id] = 1;
      if (f[8*n +: 4] != 4'hF) first[id] = TYPES[int'(f[8*n +: 4])];
      more = f[8*n+4];
      n++;
    end
    nxt = n;
    for (int b = 0; b < NB; b++) begin
      if (!isc[b] && nxt < NB) begin first[b] = f[8*nxt +: 8]; nxt++; end
    end
    for (int b = 0; b < NB; b++)
      r[66*b +: 66] = {p[56*b +: 56], first[b], (isc[b] ? 2'b10 : 2'b01)};
    return r;
  endfunction

  task automatic send_word(input logic h, input logic [63:0] f, input logic [PW-1:0] p, input int gap,
                           output logic gv, output logic ge, output logic [OW-1:0] gb,
                           output bit early, output bit linger);
    early = 0;
    @(negedge clk);
    in_valid = 1'b1; in_sow = 1'b1; in_hdr = h; in_data = f;
    early |= out_valid;
    for (int k = 0; k < 7; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0; in_sow = 1'b0;
        early |= out_valid;
      end
      @(negedge clk);
      in_valid = 1'b1; in_sow = 1'b0; in_hdr = 1'b0; in_data = p[64*k +: 64];
      early |= out_valid;
    end
    @(negedge clk);
    in_valid = 1'b0;
    gv = out_valid; ge = out_err; gb = out_blocks;
    @(negedge clk);
    linger = out_valid;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
    $finish;
  end

  initial begin : main
    logic          gv, ge;
    logic [OW-1:0] gb, ex;
    bit            early, linger, any;
    logic [PW-1:0] p;

    // R11 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_err == 1'b0, "R11 reset outputs", OW'({out_valid, out_err}), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk
    for (int v = 0; v < 8; v++) begin
      p = mk_pay(v);
      send_word(VEC[v][65], VEC[v][64:1], p, 0, gv, ge, gb, early, linger);
      chk(gv && !early && !linger, {"R8 strobe timing ", vtag[v]},
          OW'({early, gv, linger}), OW'(3'b010));
      chk(ge == VEC[v][0], {"error flag ", vtag[v]}, OW'(ge), OW'(VEC[v][0]));
      if (!VEC[v][0]) begin
        ex = model(VEC[v][65], VEC[v][64:1], p);
        chk(gb == ex, {"R1 blocks ", vtag[v]}, gb, ex);
      end
      if (v == 1) begin
        chk(gb[3*66 +: 10] == {8'h1E, 2'b10}, "R3 block 3 type and sync",
            OW'(gb[3*66 +: 10]), OW'({8'h1E, 2'b10}));
        chk(gb[0 +: 10] == {8'h11, 2'b01} && gb[4*66 +: 10] == {8'h14, 2'b01},
            "R4 leftover slot order", OW'({gb[4*66 +: 10], gb[0 +: 10]}),
            OW'({8'h14, 2'b01, 8'h11, 2'b01}));
      end
    end

    // R10 stalls inside a word
    p = mk_pay(11);
    send_word(1'b1, 64'hA7A6A5A4A3A20EF4, p, 2, gv, ge, gb, early, linger);
    ex = model(1'b1, 64'hA7A6A5A4A3A20EF4, p);
    chk(gv && !early && !linger && !ge && gb == ex, "R10 stalled word", gb, ex);

    // R10 stray beats outside a word
    any = 0;
    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sow = 1'b0; in_data = 64'hDEADBEEF00000000 | 64'(k);
      any |= out_valid;
    end
    @(negedge clk); in_valid = 1'b0; any |= out_valid;
    @(negedge clk); any |= out_valid;
    chk(!any, "R10 stray beats ignored", OW'(any), '0);

    // R9 partial word is discarded by a new start
    @(negedge clk);
    in_valid = 1'b1; in_sow = 1'b1; in_hdr = 1'b1; in_data = 64'h0000000000004251;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_sow = 1'b0; in_data = 64'h5555555555555555;
    end
    p = mk_pay(12);
    send_word(1'b0, 64'h0807060504030201, p, 0, gv, ge, gb, early, linger);
    ex = model(1'b0, 64'h0807060504030201, p);
    chk(gv && !early && !linger, "R9 one strobe after restart", OW'({early, gv, linger}), OW'(3'b010));
    chk(!ge && gb == ex, "R9 restarted word content", gb, ex);

    // R11 reset cuts a word
    @(negedge clk);
    in_valid = 1'b1; in_sow = 1'b1; in_hdr = 1'b0; in_data = '0;
    for (int k = 0; k < 3; k++) begin @(negedge clk); in_sow = 1'b0; end
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && out_err == 1'b0, "R11 outputs low in reset", OW'({out_valid, out_err}), '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    any = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); in_valid = 1'b1; in_sow = 1'b0; any |= out_valid;
    end
    @(negedge clk); in_valid = 1'b0; any |= out_valid;
    @(negedge clk); any |= out_valid;
    chk(!any, "R11 cut word gives no output", OW'(any), '0);

    // R6 followed by clean word: error does not stick (R8)
    p = mk_pay(13);
    send_word(1'b1, 64'h000000000000002F, p, 0, gv, ge, gb, early, linger);
    chk(gv && ge, "R6 error after reset", OW'({gv, ge}), OW'(2'b11));
    send_word(1'b1, 64'h1716151413121160, p, 1, gv, ge, gb, early, linger);
    ex = model(1'b1, 64'h1716151413121160, p);
    chk(gv && !ge && gb == ex, "R8 error cleared on next word", gb, ex);

    report();
    $finish;
  end
endmodule